// File: doc/BRIEF.md
# Event Status Bank with Debug-Freezable Read-Clear

This block holds three sticky event-status registers. Hardware event inputs set bits, and a read from the core port clears them as a side effect. Each register is `WIDTH` bits wide, 8 by default. The three registers are:

- a general status register;
- a non-maskable-interrupt (NMI) status register;
- a host-domain status register.

The host-domain register can also be read and cleared through a separate host read port.

A debugger asserts `freeze` so that it can inspect state without disturbing it. While `freeze` is high, a core read of the general register returns its value but leaves the register unchanged and sends no acknowledge. Two cases are exempt from freeze:

- the NMI register always clears when read;
- every access to the host-domain register keeps its destructive behaviour, whether it comes from the core port or the host port.

Each read returns its data one clock after the strobe. A one-cycle acknowledge appears on the same cycle for every access that clears a register. An event that arrives on the same cycle as a clearing read wins, so its bit stays set.

Top module: `evs_bank`

## Requirements
- R1: After reset, all three registers are zero, `core_rdata` and `host_rdata` are zero, and `core_ack` and `host_ack` are low.
- R2: A high bit on `gen_evt`, `nmi_evt` or `host_evt` sets the matching register bit at the next clock edge. The bit then stays set until a clearing read.
- R3: With `freeze` low, a core read at address 0 (general register) behaves as follows. One clock later, `core_rdata` holds the register value from the read cycle, and `core_ack` is high for exactly one cycle. The register is cleared.
- R4: With `freeze` high, a core read at address 0 returns the register value one clock later. The register keeps all its bits, and `core_ack` stays low.
- R5: A core read at address 1 (NMI register) returns the value, clears the register and pulses `core_ack`, whatever the level of `freeze`.
- R6: A core read at address 2 (host-domain register) returns the value, clears the register and pulses `core_ack`, whatever the level of `freeze`.
- R7: A `host_rd` strobe returns the host-domain register on `host_rdata` one clock later, clears the register and pulses `host_ack`, whatever the level of `freeze`.
- R8: An event bit that arrives on the same cycle as a clearing read of its register is set after that edge.
- R9: A core read at address 3 returns zero with `core_ack` low and changes no register.
- R10: When a core read at address 2 and a `host_rd` fall on the same cycle, both ports return the same value, both acknowledges pulse, and the register is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze | input | 1 | Debug freeze; suppresses read side effects on the general register |
| gen_evt | input | WIDTH | Event set bits for the general register |
| nmi_evt | input | WIDTH | Event set bits for the NMI register |
| host_evt | input | WIDTH | Event set bits for the host-domain register |
| core_rd | input | 1 | Core read strobe |
| core_addr | input | 2 | Core register address (0 general, 1 NMI, 2 host-domain, 3 unmapped) |
| core_rdata | output | WIDTH | Core read data, valid the cycle after the strobe, held until the next read |
| core_ack | output | 1 | One-cycle pulse for a clearing core read |
| host_rd | input | 1 | Host read strobe for the host-domain register |
| host_rdata | output | WIDTH | Host read data, valid the cycle after the strobe, held until the next read |
| host_ack | output | 1 | One-cycle pulse for each host read |

## Verification
The bench builds the bank at the default `WIDTH` of 8. Its patterns set the lowest and highest bit positions together (0x81, 0xA5), so a clear or a set that misses an edge bit shows up at the ports. At this width every register and address is reachable in a few cycles, including the unmapped address 3. This makes it cheap to cover each freeze level against each of the three registers, as well as the same-cycle event and dual-port races.

// File: rtl/evs_pkg.sv
package evs_pkg;

  localparam int NUM_REGS = 3;
  localparam int ADDR_W   = 2;

  localparam int IDX_GEN  = 0;
  localparam int IDX_NMI  = 1;
  localparam int IDX_HOST = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_GEN  = 2'd0,
    SEL_NMI  = 2'd1,
    SEL_HOST = 2'd2,
    SEL_NONE = 2'd3
  } evs_sel_e;

  // Address decodes to a real register.
  function automatic logic sel_mapped(evs_sel_e s);
    return (s != SEL_NONE);
  endfunction

  // Registers whose read side effects survive a debug freeze.
  function automatic logic sel_exempt(evs_sel_e s);
    return (s == SEL_NMI) || (s == SEL_HOST);
  endfunction

  // A core access clears its target when mapped and not held off by freeze.
  function automatic logic core_destructive(logic rd, evs_sel_e s, logic frz);
    return rd && sel_mapped(s) && (!frz || sel_exempt(s));
  endfunction

endpackage

// File: rtl/evs_status_reg.sv
module evs_status_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] q_o
);

  // Clear first, then merge the events, so a racing event survives.
  function automatic logic [WIDTH-1:0] next_bits(logic [WIDTH-1:0] cur,
                                                 logic [WIDTH-1:0] evt,
                                                 logic             clr);
    return (clr ? '0 : cur) | evt;
  endfunction

  logic [WIDTH-1:0] q_d;

  always_comb q_d = next_bits(q_o, evt_i, clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end

  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((q_o & $past(evt_i)) == $past(evt_i))); // R2

  AST_EVT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && (|evt_i)) |=> (q_o == $past(evt_i))); // R8

  AST_HOLD_WITHOUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((q_o & $past(q_o)) == $past(q_o))); // R4

endmodule

// File: rtl/evs_core_port.sv
module evs_core_port
  import evs_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             freeze_i,
  input  logic                             rd_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [NUM_REGS-1:0][WIDTH-1:0]   bank_i,
  output logic [NUM_REGS-1:0]              clr_o,
  output logic [WIDTH-1:0]                 rdata_o,
  output logic                             ack_o
);

  evs_sel_e         sel;
  logic             destructive;
  logic [WIDTH-1:0] rd_val;

  assign sel         = evs_sel_e'(addr_i);
  assign destructive = core_destructive(rd_i, sel, freeze_i);

  always_comb begin
    case (sel)
      SEL_GEN:  rd_val = bank_i[IDX_GEN];
      SEL_NMI:  rd_val = bank_i[IDX_NMI];
      SEL_HOST: rd_val = bank_i[IDX_HOST];
      default:  rd_val = '0;
    endcase
  end

  always_comb begin
    for (int k = 0; k < NUM_REGS; k++)
      clr_o[k] = destructive && (int'(sel) == k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
      ack_o   <= 1'b0;
    end else begin
      ack_o <= destructive;
      if (rd_i) rdata_o <= rd_val;
    end
  end

  AST_FROZEN_GEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && freeze_i && addr_i == 2'd0) |=> !ack_o); // R4

  AST_NMI_ALWAYS_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == 2'd1) |=> ack_o); // R5

  AST_HOSTREG_CORE_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == 2'd2) |=> ack_o); // R6

  AST_UNMAPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == 2'd3) |=> (!ack_o && rdata_o == '0)); // R9

  AST_ACK_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> !ack_o); // R3

endmodule

// File: rtl/evs_host_port.sv
module evs_host_port #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_i,
  input  logic [WIDTH-1:0] host_q_i,
  output logic             clr_o,
  output logic [WIDTH-1:0] rdata_o,
  output logic             ack_o
);

  // Host reads always clear; freeze is deliberately not an input here.
  assign clr_o = rd_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
      ack_o   <= 1'b0;
    end else begin
      ack_o <= rd_i;
      if (rd_i) rdata_o <= host_q_i;
    end
  end

  AST_HOST_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> ack_o); // R7

  AST_HOST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> !ack_o); // R7

endmodule

// File: rtl/evs_bank.sv
module evs_bank
  import evs_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               freeze,
  input  logic [WIDTH-1:0]   gen_evt,
  input  logic [WIDTH-1:0]   nmi_evt,
  input  logic [WIDTH-1:0]   host_evt,
  input  logic               core_rd,
  input  logic [ADDR_W-1:0]  core_addr,
  output logic [WIDTH-1:0]   core_rdata,
  output logic               core_ack,
  input  logic               host_rd,
  output logic [WIDTH-1:0]   host_rdata,
  output logic               host_ack
);

  logic [NUM_REGS-1:0][WIDTH-1:0] evt_bank;
  logic [NUM_REGS-1:0][WIDTH-1:0] q_bank;
  logic [NUM_REGS-1:0]            core_clr;
  logic [NUM_REGS-1:0]            reg_clr;
  logic                           host_clr;

  assign evt_bank[IDX_GEN]  = gen_evt;
  assign evt_bank[IDX_NMI]  = nmi_evt;
  assign evt_bank[IDX_HOST] = host_evt;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam bit IS_HOST = (i == IDX_HOST);
    assign reg_clr[i] = core_clr[i] | (IS_HOST & host_clr);

    evs_status_reg #(.WIDTH(WIDTH)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (evt_bank[i]),
      .clr_i (reg_clr[i]),
      .q_o   (q_bank[i])
    );
  end

  evs_core_port #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze_i (freeze),
    .rd_i     (core_rd),
    .addr_i   (core_addr),
    .bank_i   (q_bank),
    .clr_o    (core_clr),
    .rdata_o  (core_rdata),
    .ack_o    (core_ack)
  );

  evs_host_port #(.WIDTH(WIDTH)) u_host (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_i     (host_rd),
    .host_q_i (q_bank[IDX_HOST]),
    .clr_o    (host_clr),
    .rdata_o  (host_rdata),
    .ack_o    (host_ack)
  );

  AST_CORE_GEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd && core_addr == 2'd0) |=> (core_rdata == $past(q_bank[IDX_GEN]))); // R3

  AST_DUAL_READ_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd && core_addr == 2'd2 && host_rd) |=> (core_rdata == host_rdata)); // R10

  AST_FROZEN_GEN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd && freeze && core_addr == 2'd0) |=>
      ((q_bank[IDX_GEN] & $past(q_bank[IDX_GEN])) == $past(q_bank[IDX_GEN]))); // R4

endmodule

// File: tb/evs_bank_tb.sv
module evs_bank_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         freeze = 1'b0;
  logic [W-1:0] gen_evt = '0, nmi_evt = '0, host_evt = '0;
  logic         core_rd = 1'b0;
  logic [1:0]   core_addr = 2'd0;
  logic [W-1:0] core_rdata;
  logic         core_ack;
  logic         host_rd = 1'b0;
  logic [W-1:0] host_rdata;
  logic         host_ack;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  evs_bank #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .freeze(freeze),
    .gen_evt(gen_evt), .nmi_evt(nmi_evt), .host_evt(host_evt),
    .core_rd(core_rd), .core_addr(core_addr),
    .core_rdata(core_rdata), .core_ack(core_ack),
    .host_rd(host_rd), .host_rdata(host_rdata), .host_ack(host_ack)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic pulse_evt(int which, logic [W-1:0] v);
    case (which)
      0: gen_evt = v;
      1: nmi_evt = v;
      default: host_evt = v;
    endcase
    @(negedge clk);
    gen_evt = '0; nmi_evt = '0; host_evt = '0;
  endtask

  task automatic core_read(logic [1:0] a, output logic [W-1:0] d, output logic ack);
    core_rd = 1'b1; core_addr = a;
    @(negedge clk);
    core_rd = 1'b0;
    d = core_rdata; ack = core_ack;
  endtask

  task automatic host_read(output logic [W-1:0] d, output logic ack);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata; ack = host_ack;
  endtask

  task automatic t_reset();
    logic [W-1:0] d; logic a;
    chk("R1", "core_rdata", core_rdata, 0);
    chk("R1", "host_rdata", host_rdata, 0);
    chk("R1", "core_ack", core_ack, 0);
    chk("R1", "host_ack", host_ack, 0);
    freeze = 1'b1;
    core_read(2'd0, d, a); chk("R1", "gen after reset", d, 0);
    core_read(2'd1, d, a); chk("R1", "nmi after reset", d, 0);
    host_read(d, a);       chk("R1", "host after reset", d, 0);
    freeze = 1'b0;
  endtask

  task automatic t_sticky_frozen();
    logic [W-1:0] d; logic a;
    pulse_evt(0, 8'h81);
    @(negedge clk); @(negedge clk);
    freeze = 1'b1;
    core_read(2'd0, d, a);
    chk("R2", "gen sticky", d, 8'h81);
    chk("R4", "frozen ack", a, 0);
    core_read(2'd0, d, a);
    chk("R4", "frozen gen kept", d, 8'h81);
    pulse_evt(0, 8'h04);
    core_read(2'd0, d, a);
    chk("R2", "gen accumulates", d, 8'h85);
    freeze = 1'b0;
  endtask

  task automatic t_clear_live();
    logic [W-1:0] d; logic a;
    core_read(2'd0, d, a);
    chk("R3", "live read data", d, 8'h85);
    chk("R3", "live read ack", a, 1);
    @(negedge clk);
    chk("R3", "ack one cycle", core_ack, 0);
    freeze = 1'b1;
    core_read(2'd0, d, a);
    chk("R3", "gen cleared", d, 0);
    freeze = 1'b0;
  endtask

  task automatic t_nmi_exempt();
    logic [W-1:0] d; logic a;
    pulse_evt(1, 8'h3C);
    freeze = 1'b1;
    core_read(2'd1, d, a);
    chk("R5", "nmi data under freeze", d, 8'h3C);
    chk("R5", "nmi ack under freeze", a, 1);
    core_read(2'd1, d, a);
    chk("R5", "nmi cleared under freeze", d, 0);
    freeze = 1'b0;
  endtask

  task automatic t_host_via_core();
    logic [W-1:0] d; logic a;
    pulse_evt(2, 8'hA5);
    freeze = 1'b1;
    core_read(2'd2, d, a);
    chk("R6", "host reg via core data", d, 8'hA5);
    chk("R6", "host reg via core ack", a, 1);
    host_read(d, a);
    chk("R6", "host reg cleared by core", d, 0);
    freeze = 1'b0;
  endtask

  task automatic t_host_port();
    logic [W-1:0] d; logic a;
    pulse_evt(2, 8'h5A);
    freeze = 1'b1;
    host_read(d, a);
    chk("R7", "host port data", d, 8'h5A);
    chk("R7", "host port ack", a, 1);
    @(negedge clk);
    chk("R7", "host ack one cycle", host_ack, 0);
    host_read(d, a);
    chk("R7", "host port cleared", d, 0);
    freeze = 1'b0;
  endtask

  task automatic t_race();
    logic [W-1:0] d; logic a;
    pulse_evt(0, 8'h0F);
    gen_evt = 8'h30;
    core_read(2'd0, d, a);
    gen_evt = '0;
    chk("R8", "race read data", d, 8'h0F);
    freeze = 1'b1;
    core_read(2'd0, d, a);
    chk("R8", "racing event kept", d, 8'h30);
    freeze = 1'b0;
    core_read(2'd0, d, a);
  endtask

  task automatic t_unmapped();
    logic [W-1:0] d; logic a;
    pulse_evt(0, 8'h11);
    core_read(2'd3, d, a);
    chk("R9", "unmapped data", d, 0);
    chk("R9", "unmapped ack", a, 0);
    freeze = 1'b1;
    core_read(2'd0, d, a);
    chk("R9", "gen untouched", d, 8'h11);
    freeze = 1'b0;
    core_read(2'd0, d, a);
  endtask

  task automatic t_dual();
    logic [W-1:0] d; logic a;
    pulse_evt(2, 8'h77);
    core_rd = 1'b1; core_addr = 2'd2; host_rd = 1'b1;
    @(negedge clk);
    core_rd = 1'b0; host_rd = 1'b0;
    chk("R10", "dual core data", core_rdata, 8'h77);
    chk("R10", "dual host data", host_rdata, 8'h77);
    chk("R10", "dual core ack", core_ack, 1);
    chk("R10", "dual host ack", host_ack, 1);
    host_read(d, a);
    chk("R10", "dual cleared", d, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky_frozen();
    t_clear_live();
    t_nmi_exempt();
    t_host_via_core();
    t_host_port();
    t_race();
    t_unmapped();
    t_dual();
    done = 1'b1;
    finish_run();
  end

endmodule